// File: doc/BRIEF.md
# Sliding-Window Sorted Rank Filter

This block holds the N most recent input samples as a list kept in descending order, with the largest value at position 0. Each time an input is flagged valid, the sample that has been in the window longest is removed and the new sample is placed in its ordered slot. Both steps finish in that same clock edge, so the block never sorts the whole window again. The complete ordered window and one chosen rank (the median, the maximum or any other position) are available at the outputs.

The storage is a line of N identical word-level cells. Each cell holds a value and an age tag. On an update, each cell looks only at its own entry, its two neighbours and the incoming sample. From these it picks one of four moves: keep its own entry, take the entry from its upper neighbour, take the entry from its lower neighbour, or load the new sample. A single line that runs through the cells marks whether the entry being removed lies above a given cell. The window length N and the sample width W are parameters.

Top module: `sorted_rank_filter`

## Requirements
- R1: At every clock edge outside reset, the window positions are in non-increasing order. Position k appears on `sorted_flat[k*W +: W]`, and position 0 holds the largest value.
- R2: When `in_valid` is high at a rising edge, the window after that edge holds the N most recent accepted samples, the new sample included, in descending order.
- R3: When `in_valid` is low at a rising edge, `sorted_flat` keeps its previous value.
- R4: After reset, every position holds 0, and `out_valid` and `rank_out` are 0. The N reset zeros count as window contents and are retired one per accepted sample, so after k < N accepted samples the window holds those k samples plus N-k zeros.
- R5: After every rising edge, `rank_out` equals window position min(`rank_sel`, N-1) as it stands after that edge. A `rank_sel` value of N or more selects the last position.
- R6: `out_valid` rises at the edge that accepts the Nth sample since reset and stays high until the next reset.
- R7: Repeated equal samples are counted correctly. The window keeps exactly as many copies of a value as appear among the last N accepted samples.
- R8: Samples at the limits, 0 and 2^W-1, are stored and ranked like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `in_sample` at this edge |
| in_sample | input | W | New sample |
| rank_sel | input | clog2(N) | Window position driven onto `rank_out` |
| sorted_flat | output | N*W | Whole ordered window, position k at bits k*W +: W |
| rank_out | output | W | Registered value of the selected position |
| out_valid | output | 1 | N samples accepted since reset |

## Verification
All three outputs are registered, so each result is due one rising edge after its stimulus. A sample accepted at edge k appears in `sorted_flat` after edge k. `rank_out` shows, after that same edge, the position picked by the `rank_sel` value sampled there. `out_valid` rises at the edge that takes the Nth sample. The bench drives its inputs on the falling edge and updates its model of the window at that moment. It compares all three outputs on the next falling edge, which lies exactly one rising edge later, so every check looks at the cycle in which its result is due.

// File: rtl/rank_pkg.sv
package rank_pkg;
  // Source a cell loads from on an update.
  typedef enum logic [1:0] {
    MV_SELF  = 2'd0,
    MV_LOWER = 2'd1,
    MV_UPPER = 2'd2,
    MV_NEW   = 2'd3
  } cell_move_e;
endpackage

// File: rtl/sr_cell.sv
module sr_cell
  import rank_pkg::*;
#(
  parameter int N   = 9,
  parameter int W   = 8,
  parameter int IDX = 0,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [W-1:0]  sample,
  input  logic          del_above,   // removed entry sits at a lower index
  input  logic [W-1:0]  up_val,      // neighbour IDX-1
  input  logic [AW-1:0] up_age,
  input  logic [W-1:0]  dn_val,      // neighbour IDX+1
  input  logic [AW-1:0] dn_age,
  output logic          del_here,
  output logic [W-1:0]  val,
  output logic [AW-1:0] age,
  output logic [W-1:0]  nxt_val
);
  localparam bit HAS_UP = (IDX > 0);
  localparam bit HAS_DN = (IDX < N - 1);

  cell_move_e mv;
  logic       at_or_below;
  logic       stay_ok;
  logic       from_up;
  logic [W-1:0]  pick_v;
  logic [AW-1:0] pick_a;

  assign del_here    = (age == AW'(N - 1));
  assign at_or_below = del_above | del_here;

  always_comb begin
    // Remaining entry i (deleted entry squeezed out) stays above the new sample?
    if (!at_or_below) stay_ok = (val >= sample);
    else              stay_ok = HAS_DN && (dn_val >= sample);
    // Remaining entry i-1 falls below the new sample?
    if (!del_above)   from_up = HAS_UP && !(up_val >= sample);
    else              from_up = HAS_UP && !(val >= sample);

    if (stay_ok)      mv = at_or_below ? MV_LOWER : MV_SELF;
    else if (from_up) mv = del_above ? MV_SELF : MV_UPPER;
    else              mv = MV_NEW;

    unique case (mv)
      MV_SELF:  begin pick_v = val;    pick_a = age + 1'b1;    end
      MV_LOWER: begin pick_v = dn_val; pick_a = dn_age + 1'b1; end
      MV_UPPER: begin pick_v = up_val; pick_a = up_age + 1'b1; end
      default:  begin pick_v = sample; pick_a = '0;            end
    endcase
  end

  assign nxt_val = en ? pick_v : val;

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
      age <= AW'(IDX);
    end else if (en) begin
      val <= pick_v;
      age <= pick_a;
    end
  end

  // R2: ages stay inside the window length
  a_r2_age_in_range: assert property (@(posedge clk) disable iff (rst)
    age <= AW'(N - 1));
endmodule

// File: rtl/sr_fill_counter.sv
module sr_fill_counter #(
  parameter int N = 9,
  localparam int CW = $clog2(N + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic full
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = (en && cnt != CW'(N)) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      full <= (cnt_nx == CW'(N));
    end
  end

  // R6: once full, stays full
  a_r6_valid_stays: assert property (@(posedge clk) disable iff (rst)
    full |=> full);
endmodule

// File: rtl/sorted_rank_filter.sv
module sorted_rank_filter #(
  parameter int N = 9,
  parameter int W = 8,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_sample,
  input  logic [AW-1:0]  rank_sel,
  output logic [N*W-1:0] sorted_flat,
  output logic [W-1:0]   rank_out,
  output logic           out_valid
);
  logic [W-1:0]  c_val [N];
  logic [AW-1:0] c_age [N];
  logic [W-1:0]  c_nxt [N];
  logic [N-1:0]  c_del;
  logic [N:0]    del_chain;
  logic [AW-1:0] sel_c;

  assign del_chain[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic [W-1:0]  up_v, dn_v;
    logic [AW-1:0] up_a, dn_a;
    if (i > 0) begin : g_up
      assign up_v = c_val[i-1];
      assign up_a = c_age[i-1];
    end else begin : g_top
      assign up_v = '0;
      assign up_a = '0;
    end
    if (i < N - 1) begin : g_dn
      assign dn_v = c_val[i+1];
      assign dn_a = c_age[i+1];
    end else begin : g_bot
      assign dn_v = '0;
      assign dn_a = '0;
    end

    sr_cell #(.N(N), .W(W), .IDX(i)) u_cell (
      .clk(clk), .rst(rst), .en(in_valid), .sample(in_sample),
      .del_above(del_chain[i]),
      .up_val(up_v), .up_age(up_a), .dn_val(dn_v), .dn_age(dn_a),
      .del_here(c_del[i]), .val(c_val[i]), .age(c_age[i]),
      .nxt_val(c_nxt[i])
    );

    assign del_chain[i+1]       = del_chain[i] | c_del[i];
    assign sorted_flat[i*W +: W] = c_val[i];

    if (i < N - 1) begin : g_ord
      // R1: neighbouring positions in descending order
      a_r1_sorted_desc: assert property (@(posedge clk) disable iff (rst)
        c_val[i] >= c_val[i+1]);
    end
  end

  assign sel_c = (rank_sel > AW'(N - 1)) ? AW'(N - 1) : rank_sel;

  always_ff @(posedge clk) begin
    if (rst) rank_out <= '0;
    else     rank_out <= c_nxt[sel_c];
  end

  sr_fill_counter #(.N(N)) u_fill (
    .clk(clk), .rst(rst), .en(in_valid), .full(out_valid)
  );

  // R2: exactly one entry carries the oldest age
  a_r2_one_oldest: assert property (@(posedge clk) disable iff (rst)
    $onehot(c_del));
  // R3: idle cycles leave the window untouched
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(sorted_flat));
endmodule

// File: tb/tb_sorted_rank_filter.sv
module tb_sorted_rank_filter;
  localparam int N = 9;
  localparam int W = 8;
  localparam int AW = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [W-1:0]   in_sample = '0;
  logic [AW-1:0]  rank_sel = '0;
  logic [N*W-1:0] sorted_flat;
  logic [W-1:0]   rank_out;
  logic           out_valid;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] win [N];   // index 0 = oldest
  int accepted = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sorted_rank_filter #(.N(N), .W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .rank_sel(rank_sel), .sorted_flat(sorted_flat), .rank_out(rank_out),
    .out_valid(out_valid)
  );

  function automatic logic [N*W-1:0] exp_sorted();
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [N*W-1:0] f;
    for (int i = 0; i < N; i++) a[i] = win[i];
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0; j--)
        if (a[j] > a[j-1]) begin t = a[j]; a[j] = a[j-1]; a[j-1] = t; end
    for (int i = 0; i < N; i++) f[i*W +: W] = a[i];
    return f;
  endfunction

  task automatic check(input string req, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [N*W-1:0] e;
    int s;
    e = exp_sorted();
    s = (int'(rank_sel) > N - 1) ? N - 1 : int'(rank_sel);
    check({req, " window"}, sorted_flat, e);
    check({req, " R5 rank"}, {{(N-1)*W{1'b0}}, rank_out},
          {{(N-1)*W{1'b0}}, e[s*W +: W]});
    check({req, " R6 valid"}, {{(N*W-1){1'b0}}, out_valid},
          {{(N*W-1){1'b0}}, (accepted >= N)});
  endtask

  // drive at negedge, model follows, compare one rising edge later
  task automatic step(input logic v, input logic [W-1:0] s,
                      input logic [AW-1:0] sel, input string req);
    in_valid  = v;
    in_sample = s;
    rank_sel  = sel;
    if (v) begin
      for (int i = 0; i < N - 1; i++) win[i] = win[i+1];
      win[N-1] = s;
      accepted++;
    end
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) win[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4: reset state
    check_all("R4 reset");

    // R4: partial fill keeps reset zeros; R2 ordering
    step(1'b1, 8'd50, AW'(0), "R4 fill");
    step(1'b1, 8'd20, AW'(1), "R4 fill");
    step(1'b1, 8'd80, AW'(0), "R2 fill");
    // R3: idle cycles with changing rank_sel
    step(1'b0, 8'd99, AW'(2), "R3 idle");
    step(1'b0, 8'd1,  AW'(N-1), "R3 idle");
    for (int i = 0; i < N - 3; i++)
      step(1'b1, W'(10 * i + 5), AW'(N/2), "R6 fill");
    // R5: out-of-range selector clamps to last position
    step(1'b1, 8'd33, AW'(15), "R5 clamp");
    step(1'b0, 8'd0,  AW'(N), "R5 clamp");
    // R7: runs of equal values
    for (int i = 0; i < 2 * N; i++)
      step(1'b1, (i % 3 == 0) ? 8'd7 : 8'd9, AW'(i % N), "R7 dup");
    // R8: extremes
    for (int i = 0; i < N + 2; i++)
      step(1'b1, (i % 2) ? 8'hFF : 8'h00, AW'(0), "R8 ext");
    step(1'b1, 8'hFF, AW'(N-1), "R8 ext");
    // R1 R2: random mix, narrow range for ties
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] s;
      s = (i % 4 == 0) ? W'($urandom_range(0, 3)) : W'($urandom);
      step(($urandom_range(0, 4) != 0), s, AW'($urandom_range(0, 15)),
           "R1 R2 rand");
    end
    // R4 R6: reset again mid-stream
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    rank_sel = '0;
    for (int i = 0; i < N; i++) win[i] = '0;
    accepted = 0;
    @(negedge clk);
    check_all("R4 R6 rereset");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule